// File: doc/BRIEF.md
# Debug Register File with Alias and Fault Rules

This block keeps the state for a processor's hardware breakpoint unit: four slot address registers, a status register and a control register. A single request port addresses them with a 3-bit index. Each request is either a read or a write. The block answers reads with registered data, and it signals a one-cycle illegal-opcode fault when a request is not allowed.

Indices 4 and 5 are legacy aliases of the status register (index 6) and the control register (index 7). When the debug-extensions input is high, those two indices are no longer aliases and any access to them faults.

A write that affects how a slot is armed raises per-slot strobes: a remove strobe and an insert strobe. The matching engine downstream uses them to tear down and rebuild its watch setup for that slot. The block also keeps a flag that tells the core whether port I/O must be checked against the slots.

Control register layout, per slot i (0..3):
- Bit 2i is the local enable and bit 2i+1 is the global enable. A slot is enabled when either of them is set.
- Bits 16+4i..17+4i hold the slot type: 00 instruction, 01 data write, 10 port I/O, 11 data read/write.
- Bits 18+4i..19+4i hold the length.

Top module: `dbg_reg_ctl`

## Requirements
- R1: After reset the four address registers read 0, the status register reads 0xFFFF0FF0, the control register reads 0x00000400, the I/O flag is low, and no fault or strobe is active.
- R2: With debug extensions off or on, indices 0 to 3 write and read back the four address registers unchanged.
- R3: A write to index 6 stores the data ORed with 0xFFFF0FF0.
- R4: A write to index 7 stores the data with bit 10 forced to 1.
- R5: With debug extensions off, index 4 reads and writes the status register and index 5 reads and writes the control register, with the same masking as R3 and R4.
- R6: With debug extensions on, a read or write of index 4 or 5 raises the fault output for exactly one cycle, the cycle after the request. No register changes, the read data keeps its previous value, and no strobe fires. Indices 6 and 7 do not fault.
- R7: A write to address register i raises remove[i] and insert[i] for one cycle, but only when slot i is enabled and its type is not port I/O (10). Otherwise no strobe fires.
- R8: When a control write changes only bits 7:0, only slots whose enabled state flipped get a strobe: remove if the slot became disabled, insert if it became enabled.
- R9: When a control write changes any bit above bit 7, remove fires for all four slots and insert fires for every slot enabled in the new value.
- R10: After each control write, the I/O flag is high exactly when some enabled slot has type 10 in the new value. Other writes leave the flag unchanged.
- R11: Read data, the fault pulse and the strobes appear in the cycle after the request. The fault pulse and the strobes last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | Register index |
| req_wdata | input | W | Write data |
| dbgext_en | input | 1 | Debug-extensions enable |
| rd_data | output | W | Registered read data |
| fault | output | 1 | Illegal-opcode fault pulse |
| rearm_remove | output | 4 | Per-slot remove strobe |
| rearm_insert | output | 4 | Per-slot insert strobe |
| io_trap_active | output | 1 | Some enabled slot watches port I/O |

## Verification
The bench builds the block with its defaults: a 32-bit data path, the 0xFFFF0FF0 status mask and control bit 10 as the fixed one. With these values every fixed-ones bit and every slot's type and enable fields can be checked with literal words. The vector walk covers both paths of a control write: the enable-only change and the full re-arm. It reaches alias and fault behaviour under both settings of the extensions bit, and it checks that a faulting read leaves the previous read data in place.

// File: rtl/dbg_reg_ctl.sv
module dbg_reg_ctl #(
  parameter int              W            = 32,
  parameter logic [W-1:0]    STAT_ONES    = 32'hFFFF0FF0,
  parameter int              CTRL_ONE_BIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [2:0]   req_idx,
  input  logic [W-1:0] req_wdata,
  input  logic         dbgext_en,
  output logic [W-1:0] rd_data,
  output logic         fault,
  output logic [3:0]   rearm_remove,
  output logic [3:0]   rearm_insert,
  output logic         io_trap_active
);
  localparam int           NSLOT     = 4;
  localparam int           EN_BITS   = 2 * NSLOT;
  localparam int           TYPE_BASE = 16;
  localparam logic [1:0]   TYPE_IO   = 2'b10;
  localparam logic [W-1:0] CTRL_ONES = W'(1) << CTRL_ONE_BIT;
  localparam logic [W-1:0] EN_MASK   = (W'(1) << EN_BITS) - W'(1);

  logic [W-1:0] addr_q [NSLOT];
  logic [W-1:0] status_q, ctrl_q;

  wire       alias_idx = req_idx[2:1] == 2'b10;
  wire       bad       = req_valid && alias_idx && dbgext_en;
  wire [2:0] eff_idx   = alias_idx ? {2'b11, req_idx[0]} : req_idx;
  wire       do_wr     = req_valid && req_write && !bad;
  wire       do_rd     = req_valid && !req_write && !bad;

  wire [W-1:0] ctrl_new = req_wdata | CTRL_ONES;
  wire         only_en  = ((ctrl_q ^ ctrl_new) & ~EN_MASK) == '0;

  logic [NSLOT-1:0] en_old, en_new, arm_ok;
  logic             io_new;

  always_comb begin
    io_new = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      en_old[i] = ctrl_q[2*i] | ctrl_q[2*i+1];
      en_new[i] = ctrl_new[2*i] | ctrl_new[2*i+1];
      arm_ok[i] = en_old[i] && (ctrl_q[TYPE_BASE+4*i +: 2] != TYPE_IO);
      if (en_new[i] && ctrl_new[TYPE_BASE+4*i +: 2] == TYPE_IO) io_new = 1'b1;
    end
  end

  wire [W-1:0] rd_mux = eff_idx[2] ? (eff_idx[0] ? ctrl_q : status_q)
                                   : addr_q[eff_idx[1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) addr_q[i] <= '0;
      status_q       <= STAT_ONES;
      ctrl_q         <= CTRL_ONES;
      rd_data        <= '0;
      fault          <= 1'b0;
      rearm_remove   <= '0;
      rearm_insert   <= '0;
      io_trap_active <= 1'b0;
    end else begin
      fault        <= bad;
      rearm_remove <= '0;
      rearm_insert <= '0;
      if (do_rd) rd_data <= rd_mux;
      if (do_wr) begin
        if (!eff_idx[2]) begin
          addr_q[eff_idx[1:0]] <= req_wdata;
          if (arm_ok[eff_idx[1:0]]) begin
            rearm_remove[eff_idx[1:0]] <= 1'b1;
            rearm_insert[eff_idx[1:0]] <= 1'b1;
          end
        end else if (!eff_idx[0]) begin
          status_q <= req_wdata | STAT_ONES;
        end else begin
          ctrl_q         <= ctrl_new;
          io_trap_active <= io_new;
          if (only_en) begin
            rearm_remove <= (en_old ^ en_new) & ~en_new;
            rearm_insert <= (en_old ^ en_new) & en_new;
          end else begin
            rearm_remove <= '1;
            rearm_insert <= en_new;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbg_reg_ctl_chk.sv
module dbg_reg_ctl_chk #(
  parameter int           W            = 32,
  parameter logic [W-1:0] STAT_ONES    = 32'hFFFF0FF0,
  parameter int           CTRL_ONE_BIT = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_write,
  input logic [2:0]   req_idx,
  input logic         dbgext_en,
  input logic         fault,
  input logic [3:0]   rearm_remove,
  input logic [3:0]   rearm_insert,
  input logic         io_trap_active,
  input logic [W-1:0] status_q,
  input logic [W-1:0] ctrl_q
);
  logic [3:0] en_now;
  logic       io_any;
  always_comb begin
    io_any = 1'b0;
    for (int i = 0; i < 4; i++) begin
      en_now[i] = ctrl_q[2*i] | ctrl_q[2*i+1];
      if (en_now[i] && ctrl_q[16+4*i +: 2] == 2'b10) io_any = 1'b1;
    end
  end

  AST_STATUS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & STAT_ONES) == STAT_ONES);                                   // R3
  AST_CTRL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTRL_ONE_BIT]);                                                   // R4
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && req_idx[2:1] == 2'b10 && dbgext_en));       // R6
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(status_q) && $stable(ctrl_q) && rearm_remove == '0 && rearm_insert == '0)); // R6
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rearm_remove | rearm_insert)) |-> $past(req_valid && req_write));     // R7
  AST_INSERT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_insert & ~en_now) == '0);                                         // R8
  AST_IO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    io_trap_active == io_any);                                               // R10
endmodule

bind dbg_reg_ctl dbg_reg_ctl_chk #(.W(W), .STAT_ONES(STAT_ONES), .CTRL_ONE_BIT(CTRL_ONE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_idx(req_idx), .dbgext_en(dbgext_en), .fault(fault),
  .rearm_remove(rearm_remove), .rearm_insert(rearm_insert),
  .io_trap_active(io_trap_active), .status_q(status_q), .ctrl_q(ctrl_q)
);

// File: tb/sim_dbg_reg_ctl.sv
module sim_dbg_reg_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, dbgext_en = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        fault, io_trap_active;
  logic [3:0]  rearm_remove, rearm_insert;
  int vecs = 0, bad = 0;

  always #2.5 clk = ~clk;

  dbg_reg_ctl u0 (.*);

  typedef struct packed {
    logic        wr;
    logic [2:0]  idx;
    logic [31:0] wd;
    logic        ext;
    logic [31:0] rd;
    logic        chk_rd;
    logic        flt;
    logic [3:0]  rm;
    logic [3:0]  ins;
    logic        io;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 32'h00001000, 1'b0, 32'h0,        1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 4'd2},  // R2 write idle slot
    '{1'b0, 3'd0, 32'h0,        1'b0, 32'h00001000, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd7, 32'h00000003, 1'b0, 32'h0,        1'b0, 1'b0, 4'h0, 4'h1, 1'b0, 4'd8},  // R8 slot0 on
    '{1'b1, 3'd0, 32'h00002000, 1'b0, 32'h0,        1'b0, 1'b0, 4'h1, 4'h1, 1'b0, 4'd7},  // R7 re-arm slot0
    '{1'b0, 3'd5, 32'h0,        1'b0, 32'h00000403, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd5},  // R5 alias read ctrl
    '{1'b1, 3'd4, 32'h00000001, 1'b0, 32'h0,        1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 4'd5},  // R5 alias write status
    '{1'b0, 3'd6, 32'h0,        1'b0, 32'hFFFF0FF1, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd3},  // R3
    '{1'b1, 3'd5, 32'h00200007, 1'b0, 32'h0,        1'b0, 1'b0, 4'hF, 4'h3, 1'b1, 4'd9},  // R9 R10 type change
    '{1'b1, 3'd1, 32'h00003000, 1'b0, 32'h0,        1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 4'd7},  // R7 I/O slot no strobe
    '{1'b0, 3'd1, 32'h0,        1'b0, 32'h00003000, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 4'd2},  // R2
    '{1'b1, 3'd7, 32'h00200001, 1'b0, 32'h0,        1'b0, 1'b0, 4'h2, 4'h0, 1'b0, 4'd8},  // R8 slot1 off, slot0 stays
    '{1'b1, 3'd5, 32'hFFFFFFFF, 1'b1, 32'h0,        1'b0, 1'b1, 4'h0, 4'h0, 1'b0, 4'd6},  // R6 faulting write
    '{1'b0, 3'd4, 32'h0,        1'b1, 32'h00003000, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0, 4'd6},  // R6 faulting read keeps data
    '{1'b0, 3'd7, 32'h0,        1'b0, 32'h00200401, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd6},  // R6 ctrl untouched
    '{1'b0, 3'd7, 32'h0,        1'b1, 32'h00200401, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd6},  // R6 idx7 legal with ext
    '{1'b0, 3'd6, 32'h0,        1'b0, 32'hFFFF0FF1, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd6},  // R6 status untouched
    '{1'b1, 3'd3, 32'hDEADBEEF, 1'b1, 32'h0,        1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 4'd2},  // R2 ext on, disabled slot
    '{1'b0, 3'd3, 32'h0,        1'b1, 32'hDEADBEEF, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd6, 32'h00000000, 1'b0, 32'h0,        1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 4'd3},  // R3
    '{1'b0, 3'd4, 32'h0,        1'b0, 32'hFFFF0FF0, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4'd5}   // R5
  };

  task automatic op(input logic wr, input logic [2:0] idx, input logic [31:0] wd, input logic ext);
    req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = wd; dbgext_en = ext;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check(input logic [31:0] exp_rd, input logic chk_rd, input logic flt,
                       input logic [3:0] rm, input logic [3:0] ins, input logic io, input int r);
    vecs++;
    if ((chk_rd && rd_data !== exp_rd) || fault !== flt || rearm_remove !== rm ||
        rearm_insert !== ins || io_trap_active !== io) begin
      bad++;
      $display("FAIL R%0d: got rd=%h flt=%b rm=%h ins=%h io=%b, exp rd=%h flt=%b rm=%h ins=%h io=%b",
               r, rd_data, fault, rearm_remove, rearm_insert, io_trap_active,
               exp_rd, flt, rm, ins, io);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check(32'h0, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 1);
    for (int s = 0; s < 4; s++) begin
      op(1'b0, 3'(s), 32'h0, 1'b0);
      check(32'h0, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 1);
    end
    op(1'b0, 3'd6, 32'h0, 1'b0); check(32'hFFFF0FF0, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 1);
    op(1'b0, 3'd7, 32'h0, 1'b0); check(32'h00000400, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 1);

    for (int v = 0; v < NV; v++) begin
      op(VEC[v].wr, VEC[v].idx, VEC[v].wd, VEC[v].ext);
      check(VEC[v].rd, VEC[v].chk_rd, VEC[v].flt, VEC[v].rm, VEC[v].ins, VEC[v].io, int'(VEC[v].req));
    end

    // R11 strobes gone one cycle later
    op(1'b1, 3'd7, 32'h00000000, 1'b0);
    check(32'h0, 1'b0, 1'b0, 4'hF, 4'h0, 1'b0, 9);  // R9 full re-arm, nothing enabled
    @(negedge clk);
    check(32'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 11); // R11
    op(1'b0, 3'd7, 32'h0, 1'b0);
    check(32'h00000400, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 4); // R4
    op(1'b1, 3'd4, 32'h0, 1'b1);
    check(32'h0, 1'b0, 1'b1, 4'h0, 4'h0, 1'b0, 6);
    @(negedge clk);
    check(32'h0, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 11); // R11 fault one cycle

    // R1 mid-run reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    op(1'b0, 3'd3, 32'h0, 1'b0);
    check(32'h0, 1'b1, 1'b0, 4'h0, 4'h0, 1'b0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R11: watchdog expired, got running, exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule